// File: doc/BRIEF.md
# Power-Up Recall Mode Controller

This controller sits beside an emulated nonvolatile SRAM and decides when the memory serves ordinary reads and writes and when it is busy moving data out of its nonvolatile shadow copy. Two digital flags from external voltage comparators drive it. One says the supply has dropped below the reset level. The other says the supply has climbed above the higher switch level. A recall request is armed at reset and again on every low-supply indication. The request is held until the supply is good once more, and only then does a recall begin. The gap between the two thresholds gives hysteresis, so a supply hovering near one level cannot start a recall twice.

A recall lasts a fixed number of clock cycles. During its first 2**ADDR_W cycles it steps through every byte address, one per clock. On each of those cycles it emits a copy write carrying the shadow data into the working array. While a recall runs, or while the neighbouring store sequencer reports it is busy, the host's chip-enable and write-enable are gated off from the array. A write-enable that is still active on the last recall cycle would corrupt the array, so this condition is flagged. A low-supply flag that arrives during a recall abandons it and re-arms the request.

Top module: `nv_recall_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (SRAM), and `busy`, `recall_start`, `recall_done` and `write_collision` are 0. A recall request is pending from reset.
- R2: A recall starts only when a request is pending, `pwr_ok` is 1, `pwr_low` is 0 and `store_busy` is 0. The start is registered. `recall_start` is a one-cycle pulse in the first cycle `busy` is 1.
- R3: `busy` stays 1 for exactly RESTORE_CYCLES cycles. `recall_done` is a one-cycle pulse in the first cycle after `busy` falls.
- R4: In the k-th busy cycle (k counted from 0), `cp_wr` is 1 with `cp_addr` equal to k for k below 2**ADDR_W, and `cp_wdata` equals `shadow_rdata`. In every other cycle `cp_wr` is 0.
- R5: `mode` is 1 whenever a recall runs or `store_busy` is 1. In that state `sram_ce` and `sram_we` are 0. Otherwise `sram_ce` equals `host_ce`, and `sram_we` equals `host_ce` AND `host_we`.
- R6: Any number of `pwr_low` pulses while idle arm a single request and produce exactly one recall. After it completes, no further recall starts while `pwr_ok` stays 1 and `pwr_low` stays 0.
- R7: `pwr_low` at 1 during a recall ends it at the next edge. `busy` and `cp_wr` go to 0 and no `recall_done` is given. The request is re-armed, and a fresh, full recall starts once the supply is good.
- R8: `write_collision` becomes 1 together with `recall_done` if `host_ce` and `host_we` were both 1 in the last busy cycle, and becomes 0 with it otherwise. The flag holds its value until the next `recall_start`, which clears it.
- R9: `pwr_low` at 1 blocks a start even when `pwr_ok` is 1. The recall begins the cycle after `pwr_low` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| pwr_low | input | 1 | Supply below reset threshold |
| pwr_ok | input | 1 | Supply above switch threshold |
| store_busy | input | 1 | Store transfer running in the store sequencer |
| host_ce | input | 1 | Host chip-enable request |
| host_we | input | 1 | Host write-enable request |
| shadow_rdata | input | DATA_W | Shadow array data at `cp_addr` |
| sram_ce | output | 1 | Gated chip-enable to working array |
| sram_we | output | 1 | Gated write-enable to working array |
| mode | output | 1 | 0 = SRAM mode, 1 = nonvolatile transfer mode |
| busy | output | 1 | Recall in progress |
| recall_start | output | 1 | One-cycle pulse at recall start |
| recall_done | output | 1 | One-cycle pulse at recall completion |
| write_collision | output | 1 | Write-enable was active at recall end |
| cp_addr | output | ADDR_W | Copy address into both arrays |
| cp_wr | output | 1 | Copy write strobe to working array |
| cp_wdata | output | DATA_W | Copy write data |

## Verification
The assertions check several properties on every cycle: access gating in transfer mode, the start conditions and the pairing of the start pulse with the rise of `busy`, the copy address stepping by one, and the exact busy length before each completion. They also check that an abort suppresses completion, and that a collision flag only ever rises together with a completion. Other behaviours can only be shown by the bench's scenarios. These are that a whole run of low pulses yields exactly one recall, that no second recall follows while the supply stays good, that the working array ends up holding the shadow contents, and that the collision flag survives idle cycles and clears at the next start.

// File: rtl/nv_recall_ctrl.sv
module nv_recall_ctrl #(
  parameter int ADDR_W         = 13,
  parameter int DATA_W         = 8,
  parameter int RESTORE_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_low,
  input  logic              pwr_ok,
  input  logic              store_busy,
  input  logic              host_ce,
  input  logic              host_we,
  input  logic [DATA_W-1:0] shadow_rdata,
  output logic              sram_ce,
  output logic              sram_we,
  output logic              mode,
  output logic              busy,
  output logic              recall_start,
  output logic              recall_done,
  output logic              write_collision,
  output logic [ADDR_W-1:0] cp_addr,
  output logic              cp_wr,
  output logic [DATA_W-1:0] cp_wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(RESTORE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic req, run, start_q, done_q, coll_q;

  wire last = run && (cnt == CNT_W'(RESTORE_CYCLES - 1));
  wire go   = !run && req && pwr_ok && !pwr_low && !store_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req     <= 1'b1;
      run     <= 1'b0;
      cnt     <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      start_q <= go;
      done_q  <= 1'b0;
      if (run && pwr_low) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (go) begin
        run    <= 1'b1;
        req    <= 1'b0;
        cnt    <= '0;
        coll_q <= 1'b0;
      end else if (last) begin
        run    <= 1'b0;
        cnt    <= '0;
        done_q <= 1'b1;
        coll_q <= host_ce && host_we;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
      if (pwr_low) req <= 1'b1;
    end
  end

  assign busy            = run;
  assign mode            = run || store_busy;
  assign recall_start    = start_q;
  assign recall_done     = done_q;
  assign write_collision = coll_q;
  assign sram_ce         = host_ce && !mode;
  assign sram_we         = host_ce && host_we && !mode;
  assign cp_wr           = run && (int'(cnt) < DEPTH);
  assign cp_addr         = cnt[ADDR_W-1:0];
  assign cp_wdata        = shadow_rdata;
endmodule

module nv_recall_ctrl_chk #(
  parameter int ADDR_W         = 13,
  parameter int RESTORE_CYCLES = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_low,
  input logic              pwr_ok,
  input logic              store_busy,
  input logic              mode,
  input logic              busy,
  input logic              sram_ce,
  input logic              sram_we,
  input logic              recall_start,
  input logic              recall_done,
  input logic              write_collision,
  input logic [ADDR_W-1:0] cp_addr,
  input logic              cp_wr
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> (!sram_ce && !sram_we));
  assert_mode_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> $rose(busy));
  assert_rise_has_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> recall_start);
  assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_ok && !pwr_low && !store_busy));
  assert_copy_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_wr |-> busy);
  assert_copy_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr && $past(cp_wr)) |-> (cp_addr == ADDR_W'($past(cp_addr) + 1'b1)));
  assert_copy_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> (cp_wr && cp_addr == '0));
  assert_done_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |-> (!busy && busy_len == RESTORE_CYCLES));
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwr_low) |=> (!busy && !recall_done));
  assert_collision_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_collision) |-> recall_done);
endmodule

bind nv_recall_ctrl nv_recall_ctrl_chk #(
  .ADDR_W(ADDR_W), .RESTORE_CYCLES(RESTORE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .pwr_ok(pwr_ok),
  .store_busy(store_busy), .mode(mode), .busy(busy), .sram_ce(sram_ce),
  .sram_we(sram_we), .recall_start(recall_start), .recall_done(recall_done),
  .write_collision(write_collision), .cp_addr(cp_addr), .cp_wr(cp_wr)
);

// File: tb/nv_recall_ctrl_bench.sv
module nv_recall_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int RC = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic pwr_low = 1, pwr_ok = 0, store_busy = 0, host_ce = 0, host_we = 0;
  logic [DW-1:0] shadow_rdata;
  logic sram_ce, sram_we, mode, busy, recall_start, recall_done, write_collision;
  logic [AW-1:0] cp_addr;
  logic cp_wr;
  logic [DW-1:0] cp_wdata;
  logic [DW-1:0] work [DEPTH];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_recall_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RESTORE_CYCLES(RC)) u_nv_recall_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .pwr_ok(pwr_ok),
    .store_busy(store_busy), .host_ce(host_ce), .host_we(host_we),
    .shadow_rdata(shadow_rdata), .sram_ce(sram_ce), .sram_we(sram_we),
    .mode(mode), .busy(busy), .recall_start(recall_start),
    .recall_done(recall_done), .write_collision(write_collision),
    .cp_addr(cp_addr), .cp_wr(cp_wr), .cp_wdata(cp_wdata));

  function automatic logic [DW-1:0] shadow_val(int a);
    return DW'(a * 37 + 'h5A);
  endfunction

  assign shadow_rdata = shadow_val(int'(cp_addr));

  always @(posedge clk) if (cp_wr) work[cp_addr] <= cp_wdata;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_start(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n && !seen; i++) begin
      @(negedge clk);
      if (recall_start) seen = 1;
    end
    chk(seen, req, "recall_start seen", int'(seen), 1);
  endtask

  task automatic pulse_low();
    pwr_low = 1;
    @(negedge clk);
    pwr_low = 0;
  endtask

  // Call on the negedge where recall_start was seen (busy cycle 0).
  task automatic walk(bit we_last, bit check_mem);
    for (int k = 0; k < RC; k++) begin
      if (k > 0) @(negedge clk);
      chk(busy && mode, "R3", "busy during recall", int'(busy), 1);
      chk(recall_start == (k == 0), "R2", "start pulse width", int'(recall_start), int'(k == 0));
      chk(cp_wr == (k < DEPTH), "R4", "copy strobe", int'(cp_wr), int'(k < DEPTH));
      if (k < DEPTH) begin
        chk(int'(cp_addr) == k, "R4", "copy address", int'(cp_addr), k);
        chk(cp_wdata == shadow_val(k), "R4", "copy data", int'(cp_wdata), int'(shadow_val(k)));
      end
      chk(!sram_ce && !sram_we, "R5", "gated enables", int'(sram_ce), 0);
      if (k == RC - 1 && we_last) begin host_ce = 1; host_we = 1; end
    end
    @(negedge clk);
    chk(!busy, "R3", "busy falls after restore time", int'(busy), 0);
    chk(recall_done, "R3", "done pulse", int'(recall_done), 1);
    chk(write_collision == we_last, "R8", "collision flag at end", int'(write_collision), int'(we_last));
    chk(sram_ce == host_ce && sram_we == (host_ce && host_we), "R5", "enables pass", int'(sram_ce), int'(host_ce));
    host_we = 0;
    @(negedge clk);
    chk(!recall_done, "R3", "done is one cycle", int'(recall_done), 0);
    if (check_mem)
      for (int a = 0; a < DEPTH; a++)
        chk(work[a] == shadow_val(a), "R4", "working array content", int'(work[a]), int'(shadow_val(a)));
  endtask

  task automatic t_power_up();
    host_ce = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mode && !busy, "R1", "reset mode/busy", int'(mode), 0);
    chk(!recall_start && !recall_done, "R1", "reset pulses", int'(recall_start), 0);
    chk(!write_collision, "R1", "reset collision", int'(write_collision), 0);
    pwr_low = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy, "R2", "no start without pwr_ok", int'(busy), 0);
    end
    chk(sram_ce, "R5", "idle enable passes", int'(sram_ce), 1);
    pwr_ok = 1;
    expect_start(1, "R1");
    walk(0, 1);
  endtask

  task automatic t_no_repeat_r6();
    int starts = 0;
    for (int i = 0; i < 3 * RC; i++) begin
      @(negedge clk);
      if (recall_start || busy) starts++;
    end
    chk(starts == 0, "R6", "no second recall while supply good", starts, 0);
    pwr_ok = 0;
    for (int p = 0; p < 3; p++) begin
      pulse_low();
      @(negedge clk);
    end
    pwr_ok = 1;
    expect_start(1, "R6");
    walk(0, 1);
    starts = 0;
    for (int i = 0; i < 2 * RC; i++) begin
      @(negedge clk);
      if (recall_start) starts++;
    end
    chk(starts == 0, "R6", "single recall for many low pulses", starts, 0);
  endtask

  task automatic t_hysteresis_r9();
    pwr_low = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy, "R9", "low flag blocks start", int'(busy), 0);
    end
    pwr_low = 0;
    expect_start(1, "R9");
    walk(0, 0);
  endtask

  task automatic t_abort_r7();
    pulse_low();
    expect_start(1, "R7");
    repeat (5) @(negedge clk);
    pwr_low = 1; pwr_ok = 0;
    @(negedge clk);
    chk(!busy && !cp_wr, "R7", "abort stops recall", int'(busy), 0);
    chk(!recall_done, "R7", "abort gives no done", int'(recall_done), 0);
    pwr_low = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy && !recall_done, "R7", "idle after abort", int'(busy), 0);
    end
    pwr_ok = 1;
    expect_start(1, "R7");
    walk(0, 1);
  endtask

  task automatic t_collision_r8();
    host_ce = 0;
    pulse_low();
    expect_start(1, "R8");
    walk(1, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(write_collision, "R8", "collision flag holds", int'(write_collision), 1);
    end
    pulse_low();
    expect_start(1, "R8");
    chk(!write_collision, "R8", "collision cleared at start", int'(write_collision), 0);
    host_ce = 0;
    walk(0, 0);
  endtask

  task automatic t_store_gate();
    host_ce = 1;
    store_busy = 1;
    @(negedge clk);
    chk(mode && !sram_ce && !sram_we, "R5", "store gates access", int'(sram_ce), 0);
    pulse_low();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy, "R2", "store blocks recall start", int'(busy), 0);
    end
    store_busy = 0;
    expect_start(1, "R2");
    walk(0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_power_up();
    t_no_repeat_r6();
    t_hysteresis_r9();
    t_abort_r7();
    t_collision_r8();
    t_store_gate();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule